// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests from peripherals and presents them to a processor core as six interrupt input lines, numbered IP2 to IP7. Each source has one enable bit and one status bit. A source reaches the core only while both bits are 1. A small bank of routing registers gives every source a 4-bit field, and that field picks the core line the source drives. Several sources may share one line. Software then reads the pending word (enable AND status) to see which source on a shared line is asserting.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the address. The enable word can be written whole, or changed bit by bit through a set alias and a clear alias. Those aliases serve the unmask, acknowledge and end-of-interrupt sequences without a read-modify-write. The status word follows the request inputs one clock later and cannot be written. At reset the routing bank loads a fixed default map, and one routing register takes a value chosen by a variant input. The block has no state machine: every register is a plain data register updated from the write port or from the request inputs.

Top module: `icu_routed_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the enable word becomes all zeros, the status word becomes all zeros, and all six `cpu_irq_o` bits are 0 after that edge.
- R2: Address 3 reads the status word. The status word equals `src_i` as sampled at the previous clock edge. Writes to address 3 change no register.
- R3: Address 4 reads the pending word, which is the enable word AND the status word. Writes to address 4 change no register.
- R4: A write to address 0 replaces the enable word with `wdata_i`. Reads of address 0, 1 and 2 all return the enable word.
- R5: A write to address 1 sets every enable bit whose `wdata_i` bit is 1 and leaves the other enable bits unchanged.
- R6: A write to address 2 clears every enable bit whose `wdata_i` bit is 1 and leaves the other enable bits unchanged.
- R7: Routing register k sits at address 5+k (k = 0..3). Source s has its 4-bit route field in register s/8, at bits [4*(s%8)+3 : 4*(s%8)]. A field value v from 2 to 7 selects line IPv, which is `cpu_irq_o` bit v-2. The values 0, 1 and 8 to 15 leave the source unrouted.
- R8: Each `cpu_irq_o` bit is the OR, over all sources, of the pending bit gated by a route field that selects that line. The output therefore follows a change on `src_i` one clock edge later, and follows a change to an enable or routing register at the edge of the write.
- R9: At reset the routing registers load a default map. Source 31 goes to IP3, sources 30, 28, 27, 26 and 25 to IP2, source 29 to IP6, sources 24 and 23 to IP5, and source 20 to IP4. All other sources are unrouted, except source 15.
- R10: Source 15 defaults to IP5 when `variant_i` is 1 during reset and to unrouted when it is 0. With the map of R9, registers 0..3 therefore reset to 0x00000000, 0x50000000 or 0x00000000, 0x50040000 and 0x32622225.
- R11: A routing register reads back the last value written to it. A write to one routing register leaves the other three unchanged.
- R12: Reads of unmapped addresses (9 to 15) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| variant_i | input | 1 | Selects the reset value of routing register 1 |
| src_i | input | 32 | Level-sensitive interrupt requests, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| cpu_irq_o | output | 6 | Core interrupt lines, bit 0 = IP2 up to bit 5 = IP7 |

## Verification
Some rules hold on every cycle, and the bound assertions check them. They cover the one-cycle tracking of the status word, the set and clear aliases, the reset values, the silence of all lines while nothing is pending, and the immunity of the enable word to writes at the read-only status address. Other behaviour can only be shown by the bench's scenarios. That includes the mapping from each of the 16 field codes of every source to one particular line, the default map under both variant settings, the OR of several sources sharing a line, and the readback of the routing registers. The bench covers these by sweeping every source through every field code and by comparing random enable and request patterns against an arithmetic model.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int unsigned ADR_MASK     = 0;
    localparam int unsigned ADR_MASK_SET = 1;
    localparam int unsigned ADR_MASK_CLR = 2;
    localparam int unsigned ADR_STATUS   = 3;
    localparam int unsigned ADR_PEND     = 4;
    localparam int unsigned ADR_ROUTE0   = 5;

    // Default line code per source; source 15 depends on the variant input.
    function automatic logic [3:0] route_reset_field(input int src, input logic variant);
        logic [3:0] code;
        case (src)
            31:                 code = 4'd3;
            29:                 code = 4'd6;
            30, 28, 27, 26, 25: code = 4'd2;
            24, 23:             code = 4'd5;
            20:                 code = 4'd4;
            15:                 code = variant ? 4'd5 : 4'd0;
            default:            code = 4'd0;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/icu_mask_reg.sv
module icu_mask_reg
    import icu_pkg::*;
#(
    parameter int unsigned SRC_N  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SRC_N-1:0]  mask_o
);

    logic [SRC_N-1:0] wbits;
    assign wbits = wdata_i[SRC_N-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (wr_en_i) begin
            if (addr_i == ADDR_W'(ADR_MASK))
                mask_o <= wbits;
            else if (addr_i == ADDR_W'(ADR_MASK_SET))
                mask_o <= mask_o | wbits;
            else if (addr_i == ADDR_W'(ADR_MASK_CLR))
                mask_o <= mask_o & ~wbits;
        end
    end

endmodule

// File: rtl/icu_route_bank.sv
module icu_route_bank
    import icu_pkg::*;
#(
    parameter int unsigned SRC_N   = 32,
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     variant_i,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        sel_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [SRC_N*FIELD_W-1:0] route_o
);

    localparam int unsigned FPR = DATA_W / FIELD_W;

    for (genvar s = 0; s < SRC_N; s++) begin : g_field
        localparam int unsigned REG_IDX = s / FPR;
        localparam int unsigned SLOT    = s % FPR;
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_o[s*FIELD_W +: FIELD_W] <= FIELD_W'(route_reset_field(s, variant_i));
            else if (wr_en_i && sel_i == ADDR_W'(REG_IDX))
                route_o[s*FIELD_W +: FIELD_W] <= wdata_i[SLOT*FIELD_W +: FIELD_W];
        end
    end

endmodule

// File: rtl/icu_line_merge.sv
module icu_line_merge #(
    parameter int unsigned SRC_N     = 32,
    parameter int unsigned FIELD_W   = 4,
    parameter int unsigned LINE_N    = 6,
    parameter int unsigned LINE_BASE = 2
) (
    input  logic [SRC_N-1:0]         pend_i,
    input  logic [SRC_N*FIELD_W-1:0] route_i,
    output logic [LINE_N-1:0]        line_o
);

    for (genvar l = 0; l < LINE_N; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < SRC_N; s++) begin
                if (pend_i[s] && route_i[s*FIELD_W +: FIELD_W] == FIELD_W'(LINE_BASE + l))
                    hit = 1'b1;
            end
        end
        assign line_o[l] = hit;
    end

endmodule

// File: rtl/icu_routed_irq.sv
module icu_routed_irq
    import icu_pkg::*;
#(
    parameter int unsigned SRC_N     = 32,
    parameter int unsigned FIELD_W   = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned LINE_N    = 6,
    parameter int unsigned LINE_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_i,
    input  logic [SRC_N-1:0]  src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LINE_N-1:0] cpu_irq_o
);

    localparam int unsigned FPR        = DATA_W / FIELD_W;
    localparam int unsigned ROUTE_REGS = (SRC_N + FPR - 1) / FPR;

    logic [SRC_N-1:0]         mask_q;
    logic [SRC_N-1:0]         status_q;
    logic [SRC_N-1:0]         pend;
    logic [SRC_N*FIELD_W-1:0] route_flat;
    logic [ADDR_W-1:0]        route_idx;
    logic                     route_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= src_i;
    end

    assign pend      = mask_q & status_q;
    assign route_idx = addr_i - ADDR_W'(ADR_ROUTE0);
    assign route_hit = (addr_i >= ADDR_W'(ADR_ROUTE0)) &&
                       (addr_i <  ADDR_W'(ADR_ROUTE0 + ROUTE_REGS));

    icu_mask_reg #(
        .SRC_N (SRC_N),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_en_i),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .mask_o (mask_q)
    );

    icu_route_bank #(
        .SRC_N  (SRC_N),
        .FIELD_W(FIELD_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .variant_i(variant_i),
        .wr_en_i  (wr_en_i && route_hit),
        .sel_i    (route_idx),
        .wdata_i  (wdata_i),
        .route_o  (route_flat)
    );

    icu_line_merge #(
        .SRC_N    (SRC_N),
        .FIELD_W  (FIELD_W),
        .LINE_N   (LINE_N),
        .LINE_BASE(LINE_BASE)
    ) u_merge (
        .pend_i (pend),
        .route_i(route_flat),
        .line_o (cpu_irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADR_MASK) || addr_i == ADDR_W'(ADR_MASK_SET) ||
            addr_i == ADDR_W'(ADR_MASK_CLR))
            rdata_o = DATA_W'(mask_q);
        else if (addr_i == ADDR_W'(ADR_STATUS))
            rdata_o = DATA_W'(status_q);
        else if (addr_i == ADDR_W'(ADR_PEND))
            rdata_o = DATA_W'(pend);
        else if (route_hit) begin
            for (int r = 0; r < ROUTE_REGS; r++) begin
                if (route_idx == ADDR_W'(r))
                    rdata_o = route_flat[r*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/icu_routed_irq_chk.sv
module icu_routed_irq_chk
    import icu_pkg::*;
#(
    parameter int unsigned SRC_N  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned LINE_N = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  src_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [LINE_N-1:0] cpu_irq_o,
    input logic [SRC_N-1:0]  mask_q,
    input logic [SRC_N-1:0]  status_q
);

    logic run_q;
    always_ff @(posedge clk) run_q <= rst_n;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && status_q == '0 && cpu_irq_o == '0)); // R1

    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> status_q == $past(src_i)); // R2

    AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(ADR_STATUS)) |=> $stable(mask_q)); // R2

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(ADR_MASK_SET)) |=>
        ((mask_q & $past(wdata_i[SRC_N-1:0])) == $past(wdata_i[SRC_N-1:0]))); // R5

    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(ADR_MASK_CLR)) |=>
        ((mask_q & $past(wdata_i[SRC_N-1:0])) == '0)); // R6

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & status_q) == '0) |-> cpu_irq_o == '0); // R8

endmodule

bind icu_routed_irq icu_routed_irq_chk #(
    .SRC_N (SRC_N),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .LINE_N(LINE_N)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cpu_irq_o(cpu_irq_o),
    .mask_q   (mask_q),
    .status_q (status_q)
);

// File: tb/test_icu_routed_irq.sv
module test_icu_routed_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_i = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [5:0]  cpu_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    icu_routed_irq i_icu_routed_irq (
        .clk(clk), .rst_n(rst_n), .variant_i(variant_i), .src_i(src_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .cpu_irq_o(cpu_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic do_reset(input logic v);
        @(negedge clk);
        rst_n = 1'b0; variant_i = v; src_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [3:0] dflt(input int s, input logic v);
        if (s == 31) return 4'd3;
        if (s == 29) return 4'd6;
        if (s == 30 || (s >= 25 && s <= 28)) return 4'd2;
        if (s == 24 || s == 23) return 4'd5;
        if (s == 20) return 4'd4;
        if (s == 15) return v ? 4'd5 : 4'd0;
        return 4'd0;
    endfunction

    function automatic logic [5:0] model_irq(input logic [31:0] m, input logic [31:0] st, input logic v);
        logic [5:0] r = '0;
        for (int s = 0; s < 32; s++) begin
            logic [3:0] c = dflt(s, v);
            if (m[s] && st[s] && c >= 2 && c <= 7) r[c-2] = 1'b1;
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] lfsr;

        // reset and default map, both variants
        for (int v = 0; v < 2; v++) begin
            do_reset(v[0]);
            rd(4'd0, d);  chk("R1 mask after reset", d, 32'h0);
            rd(4'd3, d);  chk("R1 status after reset", d, 32'h0);
            chk("R1 irq after reset", {26'h0, cpu_irq_o}, 32'h0);
            rd(4'd5, d);  chk("R9 route0 default", d, 32'h0);
            rd(4'd6, d);  chk("R10 route1 default", d, v ? 32'h5000_0000 : 32'h0);
            rd(4'd7, d);  chk("R9 route2 default", d, 32'h5004_0000);
            rd(4'd8, d);  chk("R9 route3 default", d, 32'h3262_2225);
            // all sources on under default map
            wr(4'd0, 32'hFFFF_FFFF);
            src_i = 32'hFFFF_FFFF;
            @(negedge clk);
            chk("R9 R10 default lines all on", {26'h0, cpu_irq_o},
                {26'h0, model_irq('1, '1, v[0])});
            chk("R9 expected line set", {26'h0, cpu_irq_o}, 32'h1F);
        end

        // enable word write, aliases and readback
        do_reset(1'b0);
        wr(4'd0, 32'hF0F0_F0F0);
        rd(4'd0, d); chk("R4 mask write", d, 32'hF0F0_F0F0);
        wr(4'd1, 32'h0000_000F);
        rd(4'd1, d); chk("R5 set alias", d, 32'hF0F0_F0FF);
        wr(4'd2, 32'hF000_0001);
        rd(4'd2, d); chk("R6 clear alias", d, 32'h00F0_F0FE);
        rd(4'd0, d); chk("R4 mask readback", d, 32'h00F0_F0FE);

        // status timing, pending, read-only writes, unmapped
        @(negedge clk); src_i = 32'h0000_1234;
        rd(4'd3, d); chk("R2 status before edge", d, 32'h0);
        @(negedge clk);
        rd(4'd3, d); chk("R2 status after edge", d, 32'h0000_1234);
        rd(4'd4, d); chk("R3 pending word", d, 32'h0000_1234 & 32'h00F0_F0FE);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d); chk("R2 status write ignored", d, 32'h0000_1234);
        rd(4'd0, d); chk("R2 mask unchanged by status write", d, 32'h00F0_F0FE);
        wr(4'd4, 32'h0);
        rd(4'd0, d); chk("R3 mask unchanged by pending write", d, 32'h00F0_F0FE);
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, d); chk("R12 unmapped read", d, 32'h0);
        rd(4'd0, d); chk("R12 mask unchanged", d, 32'h00F0_F0FE);
        rd(4'd8, d); chk("R12 route3 unchanged", d, 32'h3262_2225);

        // route register isolation
        wr(4'd6, 32'hA5A5_5A5A);
        rd(4'd6, d); chk("R11 route1 readback", d, 32'hA5A5_5A5A);
        rd(4'd5, d); chk("R11 route0 untouched", d, 32'h0);
        rd(4'd7, d); chk("R11 route2 untouched", d, 32'h5004_0000);

        // output latency on a request edge (default map, source 31 -> IP3)
        do_reset(1'b0);
        wr(4'd0, 32'h8000_0000);
        @(negedge clk); src_i = 32'h8000_0000;
        #1 chk("R8 irq before edge", {26'h0, cpu_irq_o}, 32'h0);
        @(negedge clk);
        chk("R8 irq one edge later", {26'h0, cpu_irq_o}, 32'h2);
        wr(4'd2, 32'h8000_0000);
        chk("R8 irq drops at mask clear", {26'h0, cpu_irq_o}, 32'h0);

        // exhaustive sweep: every source, every field code
        for (int s = 0; s < 32; s++) begin
            wr(4'd0, 32'h1 << s);
            src_i = 32'h1 << s;
            for (int c = 0; c < 16; c++) begin
                logic [31:0] exp;
                wr(4'(5 + s / 8), 32'(c) << (4 * (s % 8)));
                exp = (c >= 2 && c <= 7) ? (32'h1 << (c - 2)) : 32'h0;
                chk("R7 field code to line", {26'h0, cpu_irq_o}, exp);
            end
            wr(4'd0, 32'h0);
            chk("R8 masked source silent", {26'h0, cpu_irq_o}, 32'h0);
        end

        // random enable/request patterns against default map
        do_reset(1'b1);
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 40; n++) begin
            logic [31:0] m;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            m = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr(4'd0, m);
            src_i = lfsr;
            @(negedge clk);
            chk("R8 shared-line OR", {26'h0, cpu_irq_o}, {26'h0, model_irq(m, lfsr, 1'b1)});
            rd(4'd4, d); chk("R3 pending random", d, m & lfsr);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule